// File: doc/BRIEF.md
# Pipelined Burst SRAM Data Path with Byte-Lane Writes

This block is the data side of a pipelined synchronous burst SRAM. Each clock edge it samples one beat: an already-registered word address and a select flag from an external address sequencer, a flag telling whether the beat was opened by the processor-side strobe, the write-control inputs and a 32-bit write word. From the write controls it derives four byte-lane write strobes. It writes the chosen lanes of a small internal array on that same edge, or it loads the addressed word into the output register.

The output is a data value plus a drive flag in place of a real three-state pad. The drive flag falls on the edge after a deselect or a write beat. It also tracks the active-low output enable and the snooze input directly, with no clock involved. While snooze is high every beat is ignored and the array keeps its contents.

Top module: `bsram_datapath`

## Requirements
- R1: On a selected beat not opened by the processor strobe, a low global write enable (`gwe_n_i`) writes all four byte lanes whatever `bwe_n_i` and `bw_n_i` are.
- R2: With `gwe_n_i` high and `bwe_n_i` low, only the lanes whose `bw_n_i[i]` bit is low are written. Lane i is bits [8i+7:8i] of the word, and the other lanes keep their old value.
- R3: With `gwe_n_i` high, a beat where either `bwe_n_i` is high or all `bw_n_i` bits are high is a read: nothing is written and the output register is loaded.
- R4: A selected beat with `proc_start_i` high is always a read, whatever the write enables are.
- R5: The word at the address of a read beat sampled at a rising edge appears on `rdata_o` just after that edge. This is the second register stage after the sequencer's address register. `rdata_o` holds its value on every beat that is not a read.
- R6: After a write beat, `drive_o` is low, even if `oe_n_i` is low.
- R7: `drive_o` is high only while `oe_n_i` is low and the last sampled beat was a read. A change of `oe_n_i` reaches `drive_o` without waiting for a clock edge.
- R8: A beat with `sel_i` low makes `drive_o` low from the very next edge on (single-cycle deselect).
- R9: While `snooze_i` is high, `drive_o` is low at once, no lane is written, beats are ignored, and the stored words survive the snooze.
- R10: A write followed by a read of the same address on the next beat returns the word just written. The write word is captured on the same edge as its address.
- R11: After reset, `drive_o` is low and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| snooze_i | input | 1 | Low-power hold; ignores beats and forces drive off |
| sel_i | input | 1 | Beat selects the device (address valid) |
| proc_start_i | input | 1 | Beat was opened by the processor-side strobe |
| addr_i | input | AW | Registered word address from the sequencer |
| gwe_n_i | input | 1 | Global write enable, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| bw_n_i | input | 4 | Per-lane write enables, active low |
| wdata_i | input | 32 | Write word |
| oe_n_i | input | 1 | Output enable, active low, not clocked |
| rdata_o | output | 32 | Read word from the output register |
| drive_o | output | 1 | High when the outputs would drive the bus |

## Verification
The hardest case to reach is a change on `oe_n_i` or `snooze_i` in the middle of a cycle, while a read is live, because no edge separates it from the drive change. The bench first lands a read. It then toggles these inputs one time unit after the edge and samples `drive_o` before the next edge. It also issues writes under snooze and reads them back after snooze ends, to show the array was untouched. The byte-lane tests pre-fill a word with a known pattern so that the untouched lanes can be told apart from the written ones.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int NUM_LANES = 4;
    localparam int LANE_W    = 8;
    localparam int WORD_W    = NUM_LANES * LANE_W;

    typedef logic [NUM_LANES-1:0] lane_mask_t;
    typedef logic [WORD_W-1:0]    word_t;

    typedef enum logic [1:0] {
        BEAT_IDLE  = 2'd0,
        BEAT_READ  = 2'd1,
        BEAT_WRITE = 2'd2
    } beat_e;

    typedef struct packed {
        beat_e      kind;
        lane_mask_t lane_we;
    } beat_cmd_t;

    // Layered decode: global write over byte write over read.
    function automatic beat_cmd_t decode_beat(
        input logic       sel,
        input logic       proc,
        input logic       gwe_n,
        input logic       bwe_n,
        input lane_mask_t bw_n
    );
        beat_cmd_t cmd;
        cmd.kind    = BEAT_IDLE;
        cmd.lane_we = '0;
        if (sel) begin
            if (proc) begin
                cmd.kind = BEAT_READ;
            end else if (!gwe_n) begin
                cmd.kind    = BEAT_WRITE;
                cmd.lane_we = '1;
            end else if (!bwe_n && (bw_n != '1)) begin
                cmd.kind    = BEAT_WRITE;
                cmd.lane_we = ~bw_n;
            end else begin
                cmd.kind = BEAT_READ;
            end
        end
        return cmd;
    endfunction

endpackage

// File: rtl/bsram_beat_decode.sv
module bsram_beat_decode
    import bsram_pkg::*;
(
    input  logic       snooze_i,
    input  logic       sel_i,
    input  logic       proc_start_i,
    input  logic       gwe_n_i,
    input  logic       bwe_n_i,
    input  lane_mask_t bw_n_i,
    output beat_cmd_t  cmd_o
);

    beat_cmd_t raw_cmd;

    always_comb begin
        raw_cmd = decode_beat(sel_i, proc_start_i, gwe_n_i, bwe_n_i, bw_n_i);
        if (snooze_i) begin
            cmd_o.kind    = BEAT_IDLE;
            cmd_o.lane_we = '0;
        end else begin
            cmd_o = raw_cmd;
        end
    end

endmodule

// File: rtl/bsram_lane_array.sv
module bsram_lane_array
    import bsram_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  lane_mask_t    lane_we_i,
    input  logic [AW-1:0] addr_i,
    input  word_t         wdata_i,
    output word_t         rword_o
);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk_i) begin
            if (lane_we_i[g]) begin
                store[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rword_o[g*LANE_W +: LANE_W] = store[addr_i];
    end

endmodule

// File: rtl/bsram_out_stage.sv
module bsram_out_stage
    import bsram_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  beat_e kind_i,
    input  word_t rword_i,
    input  logic  oe_n_i,
    input  logic  snooze_i,
    output word_t rdata_o,
    output logic  drive_o
);

    word_t data_q;
    logic  live_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            data_q <= '0;
            live_q <= 1'b0;
        end else begin
            unique case (kind_i)
                BEAT_READ: begin
                    data_q <= rword_i;
                    live_q <= 1'b1;
                end
                default: live_q <= 1'b0;
            endcase
        end
    end

    assign rdata_o = data_q;
    assign drive_o = live_q & ~oe_n_i & ~snooze_i;

endmodule

// File: rtl/bsram_datapath.sv
module bsram_datapath
    import bsram_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 snooze_i,
    input  logic                 sel_i,
    input  logic                 proc_start_i,
    input  logic [AW-1:0]        addr_i,
    input  logic                 gwe_n_i,
    input  logic                 bwe_n_i,
    input  logic [NUM_LANES-1:0] bw_n_i,
    input  logic [WORD_W-1:0]    wdata_i,
    input  logic                 oe_n_i,
    output logic [WORD_W-1:0]    rdata_o,
    output logic                 drive_o
);

    beat_cmd_t  cmd;
    lane_mask_t lane_we;
    word_t      rword;

    bsram_beat_decode u_decode (
        .snooze_i     (snooze_i),
        .sel_i        (sel_i),
        .proc_start_i (proc_start_i),
        .gwe_n_i      (gwe_n_i),
        .bwe_n_i      (bwe_n_i),
        .bw_n_i       (bw_n_i),
        .cmd_o        (cmd)
    );

    assign lane_we = cmd.lane_we;

    bsram_lane_array #(.DEPTH(DEPTH)) u_array (
        .clk_i     (clk_i),
        .lane_we_i (lane_we),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rword_o   (rword)
    );

    bsram_out_stage u_out (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .kind_i   (cmd.kind),
        .rword_i  (rword),
        .oe_n_i   (oe_n_i),
        .snooze_i (snooze_i),
        .rdata_o  (rdata_o),
        .drive_o  (drive_o)
    );

endmodule

// File: rtl/bsram_datapath_chk.sv
module bsram_datapath_chk
    import bsram_pkg::*;
(
    input logic       clk_i,
    input logic       rst_i,
    input logic       snooze_i,
    input logic       sel_i,
    input logic       proc_start_i,
    input logic       gwe_n_i,
    input logic       bwe_n_i,
    input lane_mask_t bw_n_i,
    input logic       oe_n_i,
    input word_t      rdata_o,
    input logic       drive_o,
    input lane_mask_t lane_we
);

    logic wr_beat;
    logic rd_beat;
    assign wr_beat = sel_i & ~snooze_i & ~proc_start_i &
                     (~gwe_n_i | (~bwe_n_i & (bw_n_i != '1)));
    assign rd_beat = sel_i & ~snooze_i & ~wr_beat;

    // R1
    gwe_all_lanes_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i && !proc_start_i && !snooze_i && !gwe_n_i) |-> lane_we == '1);

    // R4
    proc_start_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i && proc_start_i) |-> lane_we == '0);

    // R5
    rdata_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_beat |=> $stable(rdata_o));

    // R6
    write_kills_drive_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_beat |=> !drive_o);

    // R7
    read_drives_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_beat |=> (oe_n_i || snooze_i || drive_o));

    // R8
    deselect_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !sel_i |=> !drive_o);

    // R9
    snooze_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        snooze_i |-> (!drive_o && lane_we == '0));

endmodule

bind bsram_datapath bsram_datapath_chk u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .snooze_i     (snooze_i),
    .sel_i        (sel_i),
    .proc_start_i (proc_start_i),
    .gwe_n_i      (gwe_n_i),
    .bwe_n_i      (bwe_n_i),
    .bw_n_i       (bw_n_i),
    .oe_n_i       (oe_n_i),
    .rdata_o      (rdata_o),
    .drive_o      (drive_o),
    .lane_we      (lane_we)
);

// File: tb/bsram_datapath_tb.sv
module bsram_datapath_tb;

    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          snooze = 1'b0;
    logic          sel = 1'b0;
    logic          proc = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          gwe_n = 1'b1;
    logic          bwe_n = 1'b1;
    logic [3:0]    bw_n = 4'hF;
    logic [31:0]   wdata = '0;
    logic          oe_n = 1'b0;
    logic [31:0]   rdata;
    logic          drive;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic [31:0] model [DEPTH];

    always #10 clk = ~clk;

    bsram_datapath #(.DEPTH(DEPTH)) u_dut (
        .clk_i(clk), .rst_i(rst), .snooze_i(snooze), .sel_i(sel),
        .proc_start_i(proc), .addr_i(addr), .gwe_n_i(gwe_n),
        .bwe_n_i(bwe_n), .bw_n_i(bw_n), .wdata_i(wdata),
        .oe_n_i(oe_n), .rdata_o(rdata), .drive_o(drive)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic beat(input logic s, input logic p, input logic g, input logic b,
                        input logic [3:0] bw, input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = s; proc = p; gwe_n = g; bwe_n = b; bw_n = bw; addr = a; wdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic wr_full(input logic [AW-1:0] a, input logic [31:0] d);
        beat(1, 0, 0, 1, 4'hF, a, d);
        model[a] = d;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        beat(1, 0, 1, 1, 4'hF, a, 32'h0);
    endtask

    task automatic idle();
        beat(0, 0, 1, 1, 4'hF, '0, 32'h0);
    endtask

    task automatic t_reset();
        check("R11 drive", {31'b0, drive}, 32'h0);
        check("R11 rdata", rdata, 32'h0);
    endtask

    task automatic t_global();
        beat(1, 0, 0, 0, 4'b0101, 4'd3, 32'hA5A5_5A5A);
        model[3] = 32'hA5A5_5A5A;
        rd(4'd3);
        check("R1 global write", rdata, model[3]);
        check("R5 read drive", {31'b0, drive}, 32'h1);
    endtask

    task automatic t_byte();
        wr_full(4'd5, 32'h1122_3344);
        beat(1, 0, 1, 0, 4'b1010, 4'd5, 32'hAABB_CCDD);
        rd(4'd5);
        check("R2 byte lanes 0,2", rdata, 32'h11BB_33DD);
    endtask

    task automatic t_noread();
        wr_full(4'd6, 32'hCAFE_0001);
        beat(1, 0, 1, 0, 4'hF, 4'd6, 32'h0BAD_0BAD);
        check("R3 all bw high reads", rdata, 32'hCAFE_0001);
        check("R3 read drives", {31'b0, drive}, 32'h1);
        beat(1, 0, 1, 1, 4'h0, 4'd6, 32'h0BAD_0BAD);
        rd(4'd6);
        check("R3 bwe high no write", rdata, 32'hCAFE_0001);
    endtask

    task automatic t_proc();
        beat(1, 1, 0, 0, 4'h0, 4'd3, 32'hDEAD_BEEF);
        check("R4 proc start is read", rdata, model[3]);
        check("R4 proc start drives", {31'b0, drive}, 32'h1);
        rd(4'd3);
        check("R4 no write happened", rdata, model[3]);
    endtask

    task automatic t_wroff();
        rd(4'd5);
        check("R6 pre read drive", {31'b0, drive}, 32'h1);
        beat(1, 0, 1, 0, 4'b1110, 4'd9, 32'h0000_0077);
        check("R6 byte write drops drive", {31'b0, drive}, 32'h0);
        check("R5 rdata held on write", rdata, 32'h11BB_33DD);
    endtask

    task automatic t_oe();
        rd(4'd3);
        oe_n = 1'b1; #1;
        check("R7 oe high async", {31'b0, drive}, 32'h0);
        oe_n = 1'b0; #1;
        check("R7 oe low async", {31'b0, drive}, 32'h1);
    endtask

    task automatic t_desel();
        rd(4'd3);
        idle();
        check("R8 deselect next edge", {31'b0, drive}, 32'h0);
        check("R5 rdata held idle", rdata, model[3]);
    endtask

    task automatic t_snooze();
        rd(4'd6);
        snooze = 1'b1; #1;
        check("R9 snooze drops drive", {31'b0, drive}, 32'h0);
        beat(1, 0, 0, 1, 4'hF, 4'd6, 32'hFFFF_FFFF);
        beat(1, 0, 1, 1, 4'hF, 4'd3, 32'h0);
        check("R9 read ignored", rdata, 32'hCAFE_0001);
        check("R9 drive off", {31'b0, drive}, 32'h0);
        @(negedge clk);
        snooze = 1'b0;
        rd(4'd6);
        check("R9 contents kept", rdata, 32'hCAFE_0001);
    endtask

    task automatic t_raw();
        wr_full(4'd7, 32'h7777_1234);
        rd(4'd7);
        check("R10 read after write", rdata, 32'h7777_1234);
        rd(4'd5);
        check("R5 burst beat a", rdata, 32'h11BB_33DD);
        rd(4'd3);
        check("R5 burst beat b", rdata, model[3]);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_global();
        t_byte();
        t_noread();
        t_proc();
        t_wroff();
        t_oe();
        t_desel();
        t_snooze();
        t_raw();
        idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule